// File: doc/BRIEF.md
# Dual-Mode Host Bus Channel Decoder

This block sits between one 8-bit parallel host bus and four identical serial channels. A strap input picks one of two bus styles. In strobe style every channel has its own active-low select pin, and separate active-low read and write strobes set the direction. In level style a single shared select enables the whole block. Two of the other select pins are reused as channel address bits, and the write-strobe pin is reused as a read/write direction level. The polarity of the reset pin also follows the strap.

For every access the block works out the target channel and one of eight register indices. It emits a one-cycle read or write pulse towards that channel, together with the register index. It drives the shared read data whenever a valid read addresses exactly one channel. A write is captured once for each assertion of the access, however long that assertion is held. The register files of the channels are represented by small register stubs, so reads return what was last written.

Top module: `hbus_chan_decoder`

## Requirements
- R1: With `mode_strobe`=1, a channel is accessed only while its own pin `sel_pins[i]` is 0 and all other select pins are 1. A write (`wr_n`=0, `rd_n`=1) loads `bus_in` into register `addr` of that channel.
- R2: With `mode_strobe`=1, `rd_n`=0, `wr_n`=1 and exactly one select low, `bus_oe` is 1 in the same cycle and `bus_out` equals register `addr` of that channel.
- R3: With `mode_strobe`=0, the block is selected when `sel_pins[0]`=0. The channel number is {`sel_pins[2]`,`sel_pins[1]`}, so 00, 01, 10 and 11 mean channels 0 to 3. `wr_n`=1 means read and `wr_n`=0 means write. `sel_pins[3]` has no effect.
- R4: With `mode_strobe`=0, `rd_n` has no effect on reads, writes, pulses or `bus_oe`.
- R5: Reset is active when `rst_pin`=1 in strobe mode and when `rst_pin`=0 in level mode. It acts at the clock edge and clears every channel register, every pulse and every index output to 0.
- R6: A write held active for several cycles is captured exactly once, with the `bus_in` value of its first cycle. The next write needs the access to drop for at least one edge.
- R7: The cycle after the edge that captures an access, bit i of `ch_wr_pulse` (or `ch_rd_pulse`, for the first cycle of a read) is 1 for one cycle only for the target channel i. `ch_idx[i]` then holds the `addr` of that access and keeps it until the next access to channel i.
- R8: `bus_oe` is 0 and `bus_out` is 0 whenever there is no valid read. This covers no select, more than one select low in strobe mode, and any write.
- R9: In strobe mode, `rd_n`=0 together with `wr_n`=0 is no access: no pulse, no data drive, no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| mode_strobe | input | 1 | Bus style strap: 1 strobe style, 0 level style |
| rst_pin | input | 1 | Reset pin; its polarity follows `mode_strobe` |
| sel_pins | input | 4 | Strobe style: per-channel active-low selects. Level style: bit 0 shared select, bits 2:1 channel number, bit 3 unused |
| rd_n | input | 1 | Active-low read strobe (strobe style only) |
| wr_n | input | 1 | Strobe style: active-low write strobe. Level style: 1 read, 0 write |
| addr | input | 3 | Register index within the channel |
| bus_in | input | 8 | Write data from the host bus |
| bus_out | output | 8 | Read data towards the host bus |
| bus_oe | output | 1 | Drive enable for the shared data bus |
| ch_wr_pulse | output | 4 | One-cycle write pulse per channel |
| ch_rd_pulse | output | 4 | One-cycle read pulse per channel |
| ch_idx | output | 12 | Register index of the last access, 3 bits per channel |

## Verification
The assertions assume that the strap and pins are stable synchronous levels that change only between clock edges. They also assume that the reset pin is driven to its active level from the first edge, whichever polarity the strap gives. The bench changes every input one half period after a rising edge. It starts in reset and sets the reset pin from the strap so that reset is active only where a step asks for it. The random steps do change the strap between steps, and this is allowed because the decode depends only on the present pin levels.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
    localparam int NCH = 4;
    localparam int DW  = 8;
    localparam int AW  = 3;
    localparam int CHW = $clog2(NCH);

    typedef struct packed {
        logic                    wr_seen;
        logic                    rd_seen;
        logic [NCH-1:0]          wr_pls;
        logic [NCH-1:0]          rd_pls;
        logic [NCH-1:0][AW-1:0]  idx;
    } dec_state_t;
endpackage

// File: rtl/hbd_select.sv
module hbd_select #(
    parameter int NCH = 4,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           mode_strobe,
    input  logic [NCH-1:0] sel_pins,
    input  logic           rd_n,
    input  logic           wr_n,
    output logic [NCH-1:0] chan_oh,
    output logic [CHW-1:0] chan_num,
    output logic           rd_req,
    output logic           wr_req
);
    logic [NCH-1:0] act;
    logic [CHW:0]   cnt;
    logic           hit;

    always_comb begin
        act = ~sel_pins;
        cnt = '0;
        for (int i = 0; i < NCH; i++) begin
            cnt = cnt + {{CHW{1'b0}}, act[i]};
        end
        if (mode_strobe) begin
            chan_oh = (cnt == (CHW+1)'(1)) ? act : '0;
        end else begin
            chan_oh = sel_pins[0] ? '0 : (NCH'(1) << sel_pins[CHW:1]);
        end
        chan_num = '0;
        for (int i = 0; i < NCH; i++) begin
            if (chan_oh[i]) chan_num = CHW'(i);
        end
        hit    = |chan_oh;
        rd_req = hit & (mode_strobe ? (~rd_n & wr_n) : wr_n);
        wr_req = hit & (mode_strobe ? (~wr_n & rd_n) : ~wr_n);
    end
endmodule

// File: rtl/hbd_regstub.sv
module hbd_regstub #(
    parameter int DW = 8,
    parameter int AW = 3,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ridx,
    output logic [DW-1:0] rdata
);
    logic [DEPTH-1:0][DW-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (rst) begin
            mem_d = '0;
        end else if (wr_en) begin
            mem_d[widx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rdata = mem_q[ridx];
endmodule

// File: rtl/hbus_chan_decoder.sv
module hbus_chan_decoder
    import hbd_pkg::*;
(
    input  logic                   clk,
    input  logic                   mode_strobe,
    input  logic                   rst_pin,
    input  logic [NCH-1:0]         sel_pins,
    input  logic                   rd_n,
    input  logic                   wr_n,
    input  logic [AW-1:0]          addr,
    input  logic [DW-1:0]          bus_in,
    output logic [DW-1:0]          bus_out,
    output logic                   bus_oe,
    output logic [NCH-1:0]         ch_wr_pulse,
    output logic [NCH-1:0]         ch_rd_pulse,
    output logic [NCH-1:0][AW-1:0] ch_idx
);
    logic                   rst_act;
    logic [NCH-1:0]         chan_oh;
    logic [CHW-1:0]         chan_num;
    logic                   rd_req, wr_req;
    logic                   wr_ev, rd_ev;
    logic [NCH-1:0][DW-1:0] ch_rdata;
    dec_state_t             st_d, st_q;

    // reset polarity follows the bus style strap
    assign rst_act = mode_strobe ? rst_pin : ~rst_pin;

    hbd_select #(.NCH(NCH)) u_sel (
        .mode_strobe (mode_strobe),
        .sel_pins    (sel_pins),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .chan_oh     (chan_oh),
        .chan_num    (chan_num),
        .rd_req      (rd_req),
        .wr_req      (wr_req)
    );

    // an access counts once per assertion
    assign wr_ev = wr_req & ~st_q.wr_seen;
    assign rd_ev = rd_req & ~st_q.rd_seen;

    always_comb begin
        st_d         = st_q;
        st_d.wr_seen = wr_req;
        st_d.rd_seen = rd_req;
        st_d.wr_pls  = wr_ev ? chan_oh : '0;
        st_d.rd_pls  = rd_ev ? chan_oh : '0;
        for (int i = 0; i < NCH; i++) begin
            if ((wr_ev | rd_ev) && chan_oh[i]) st_d.idx[i] = addr;
        end
        if (rst_act) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        hbd_regstub #(.DW(DW), .AW(AW)) u_regs (
            .clk   (clk),
            .rst   (rst_act),
            .wr_en (wr_ev & chan_oh[g]),
            .widx  (addr),
            .wdata (bus_in),
            .ridx  (addr),
            .rdata (ch_rdata[g])
        );
    end

    assign bus_oe      = rd_req;
    assign bus_out     = rd_req ? ch_rdata[chan_num] : '0;
    assign ch_wr_pulse = st_q.wr_pls;
    assign ch_rd_pulse = st_q.rd_pls;
    assign ch_idx      = st_q.idx;
endmodule

// File: rtl/hbd_checker.sv
module hbd_checker
    import hbd_pkg::*;
(
    input logic                   clk,
    input logic                   mode_strobe,
    input logic                   rst_pin,
    input logic [NCH-1:0]         sel_pins,
    input logic                   rd_n,
    input logic                   wr_n,
    input logic [AW-1:0]          addr,
    input logic                   bus_oe,
    input logic [NCH-1:0]         ch_wr_pulse,
    input logic [NCH-1:0]         ch_rd_pulse,
    input logic [NCH-1:0][AW-1:0] ch_idx
);
    logic rst_chk;
    assign rst_chk = mode_strobe ? rst_pin : ~rst_pin;

    // R2
    oe_strobe_chk: assert property (@(posedge clk) disable iff (rst_chk)
        (bus_oe && mode_strobe) |-> ($countones(~sel_pins) == 1 && !rd_n && wr_n));

    // R3
    oe_level_chk: assert property (@(posedge clk) disable iff (rst_chk)
        (bus_oe && !mode_strobe) |-> (!sel_pins[0] && wr_n));

    // R7
    wr_onehot_chk: assert property (@(posedge clk) disable iff (rst_chk)
        $onehot0(ch_wr_pulse));

    // R7
    rd_onehot_chk: assert property (@(posedge clk) disable iff (rst_chk)
        $onehot0(ch_rd_pulse));

    // R6
    wr_once_chk: assert property (@(posedge clk) disable iff (rst_chk)
        (|ch_wr_pulse) |=> (ch_wr_pulse == '0));

    // R5
    rst_clear_chk: assert property (@(posedge clk)
        rst_chk |=> (ch_wr_pulse == '0 && ch_rd_pulse == '0 && ch_idx == '0));

    for (genvar g = 0; g < NCH; g++) begin : g_idx
        // R7
        idx_hold_chk: assert property (@(posedge clk) disable iff (rst_chk)
            ch_wr_pulse[g] |-> (ch_idx[g] == $past(addr)));
    end
endmodule

bind hbus_chan_decoder hbd_checker u_chk (
    .clk         (clk),
    .mode_strobe (mode_strobe),
    .rst_pin     (rst_pin),
    .sel_pins    (sel_pins),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .addr        (addr),
    .bus_oe      (bus_oe),
    .ch_wr_pulse (ch_wr_pulse),
    .ch_rd_pulse (ch_rd_pulse),
    .ch_idx      (ch_idx)
);

// File: tb/hbus_chan_decoder_test.sv
`timescale 1ns/1ps
module hbus_chan_decoder_test;
    logic            clk = 1'b0;
    logic            mode_strobe = 1'b1;
    logic            rst_pin = 1'b1;
    logic [3:0]      sel_pins = 4'hF;
    logic            rd_n = 1'b1, wr_n = 1'b1;
    logic [2:0]      addr = '0;
    logic [7:0]      bus_in = '0;
    logic [7:0]      bus_out;
    logic            bus_oe;
    logic [3:0]      ch_wr_pulse, ch_rd_pulse;
    logic [3:0][2:0] ch_idx;

    int  n_chk = 0, n_fail = 0;
    bit  done = 1'b0;

    logic [7:0] m_regs [0:3][0:7];
    logic [2:0] m_idx  [0:3];
    bit         m_wseen, m_rseen;
    logic [3:0] exp_wp, exp_rp;

    always #4 clk = ~clk;

    hbus_chan_decoder uut (
        .clk(clk), .mode_strobe(mode_strobe), .rst_pin(rst_pin),
        .sel_pins(sel_pins), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .ch_wr_pulse(ch_wr_pulse), .ch_rd_pulse(ch_rd_pulse), .ch_idx(ch_idx)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // expected one-hot target from the requirements (0 = no valid target)
    function automatic logic [3:0] f_sel(bit md, logic [3:0] pins);
        logic [3:0] s;
        if (md) begin
            s = ~pins;
            return ($countones(s) == 1) ? s : 4'h0;
        end
        return pins[0] ? 4'h0 : (4'h1 << {pins[2], pins[1]});
    endfunction

    function automatic int f_num(logic [3:0] s);
        for (int i = 0; i < 4; i++) if (s[i]) return i;
        return 0;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 4; c++) begin
            m_idx[c] = '0;
            for (int r = 0; r < 8; r++) m_regs[c][r] = '0;
        end
        m_wseen = 0; m_rseen = 0; exp_wp = '0; exp_rp = '0;
    endtask

    task automatic step(string tag, bit md, bit rst_on, logic [3:0] pins,
                        bit rdn, bit wrn, logic [2:0] a, logic [7:0] d);
        logic [3:0] s;
        bit rd, wr, wev, rev;
        int ch;
        @(negedge clk);
        mode_strobe = md;
        rst_pin     = md ? rst_on : !rst_on;
        sel_pins    = pins; rd_n = rdn; wr_n = wrn; addr = a; bus_in = d;
        #1;
        s  = f_sel(md, pins);
        ch = f_num(s);
        rd = (s != 0) && (md ? (!rdn && wrn) : wrn);
        wr = (s != 0) && (md ? (!wrn && rdn) : !wrn);
        chk(rd ? tag : "R8", 32'(bus_oe), 32'(rd));
        chk(rd ? tag : "R8", 32'(bus_out), rd ? 32'(m_regs[ch][a]) : 32'h0);
        @(posedge clk); #1;
        if (rst_on) begin
            model_reset();
        end else begin
            wev = wr && !m_wseen;
            rev = rd && !m_rseen;
            exp_wp = wev ? s : 4'h0;
            exp_rp = rev ? s : 4'h0;
            if (wev) m_regs[ch][a] = d;
            if (wev || rev) m_idx[ch] = a;
            m_wseen = wr; m_rseen = rd;
        end
        chk(rst_on ? "R5" : "R7", 32'(ch_wr_pulse), 32'(exp_wp));
        chk(rst_on ? "R5" : "R7", 32'(ch_rd_pulse), 32'(exp_rp));
        for (int c = 0; c < 4; c++)
            chk(rst_on ? "R5" : "R7", 32'(ch_idx[c]), 32'(m_idx[c]));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [3:0] pins;
        bit md;
        void'($urandom(32'h5EED_0454));
        model_reset();
        // R5: reset in strobe mode (pin high)
        step("R5", 1, 1, 4'hF, 1, 1, 0, 0);
        step("R5", 1, 1, 4'hF, 1, 1, 0, 0);
        // R1/R2: write and read each channel in strobe mode
        for (int c = 0; c < 4; c++) begin
            step("R1", 1, 0, ~(4'h1 << c), 1, 0, 3'(c + 2), 8'(8'hA0 + c));
            step("R1", 1, 0, 4'hF, 1, 1, 0, 0);
        end
        for (int c = 0; c < 4; c++) begin
            step("R2", 1, 0, ~(4'h1 << c), 0, 1, 3'(c + 2), 0);
            step("R2", 1, 0, 4'hF, 1, 1, 0, 0);
        end
        // R8: two selects low on a read
        step("R8", 1, 0, 4'b1100, 0, 1, 2, 0);
        // R6: write held for three cycles with changing data
        step("R6", 1, 0, 4'b1110, 1, 0, 7, 8'h11);
        step("R6", 1, 0, 4'b1110, 1, 0, 7, 8'h22);
        step("R6", 1, 0, 4'b1110, 1, 0, 7, 8'h33);
        step("R6", 1, 0, 4'hF, 1, 1, 0, 0);
        step("R6", 1, 0, 4'b1110, 0, 1, 7, 0);
        // R9: both strobes low, then read back unchanged value
        step("R9", 1, 0, 4'b1110, 0, 0, 7, 8'h5A);
        step("R9", 1, 0, 4'hF, 1, 1, 0, 0);
        step("R9", 1, 0, 4'b1110, 0, 1, 7, 0);
        // R3: level mode, channel 2 via {A4,A3}=10, pin3 low then high
        step("R3", 0, 0, 4'b0100, 1, 0, 1, 8'hC3);
        step("R3", 0, 0, 4'hF, 1, 1, 0, 0);
        step("R3", 0, 0, 4'b1100, 1, 1, 1, 0);
        step("R3", 0, 0, 4'b0101, 1, 1, 1, 0);
        // R4: read strobe level ignored in level mode
        step("R4", 0, 0, 4'b0110, 0, 1, 5, 0);
        step("R4", 0, 0, 4'b0111, 0, 0, 5, 8'h3C);
        step("R4", 0, 0, 4'b0111, 1, 1, 0, 0);
        step("R4", 0, 0, 4'b0110, 0, 1, 5, 0);
        // R5: reset in level mode (pin low), then read back zero
        step("R5", 0, 1, 4'hF, 1, 1, 0, 0);
        step("R5", 0, 0, 4'b0100, 1, 1, 1, 0);
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            md = $urandom_range(0, 3) != 0;
            case ($urandom_range(0, 3))
                0: pins = 4'(~(4'h1 << $urandom_range(0, 3)));
                1: pins = 4'hF;
                default: pins = 4'($urandom);
            endcase
            step(md ? "R1" : "R3", md, $urandom_range(0, 63) == 0, pins,
                 1'($urandom), 1'($urandom), 3'($urandom), 8'($urandom));
        end
        finish_run();
    end
endmodule